// File: doc/BRIEF.md
# Change-of-State Digital I/O Register Block

This block is the register file of a 56-line digital I/O peripheral. It holds 24 latched output lines, samples 24 input lines, and has one 8-bit auxiliary port whose direction is chosen by a control bit. Software reaches all of it through a byte-addressed synchronous bus. The bus has an address, write data, read data, and single-cycle read and write strobes. A wide qualifier lets the four change-status bytes be read or cleared as one 32-bit word.

Every input line passes through a two-flop synchronizer. The three input banks and the auxiliary port each form one 8-line bank for change detection. Each bank has its own rising-edge enable and its own falling-edge enable. An enabled edge sets a sticky per-line flag. Software clears flags by writing ones. The interrupt output stays high while any flag is set. Any write to the top offset returns every software-visible register to zero.

Register offsets (4-bit address, one byte each):
- 0 to 2: output latches, lines 0-7, 8-15 and 16-23.
- 3: auxiliary output latch.
- 4 to 6: input levels.
- 7: auxiliary port level.
- 8 to 11: change flags for banks 0 to 3, where bank 3 is the auxiliary port.
- 12: control.
- 13: unused.
- 14: edge enables.
- 15: interrupt level on read, soft reset on write.

Top module: `cosio_regs`

## Requirements
- R1: Offsets 0, 1 and 2 latch written bytes onto output lines 0-7, 8-15 and 16-23. Offset 3 latches the auxiliary output byte. Reading any of these four offsets returns the latched value.
- R2: Offsets 4, 5 and 6 read the synchronized levels of input lines 0-7, 8-15 and 16-23. Writes to offsets 4 to 7 change no output, no register and no flag.
- R3: Bit 1 of the control register at offset 12 drives the auxiliary output enable. When this bit is 0, the auxiliary port is an input.
- R4: In the enable register at offset 14, bit n (n = 0..3) enables rising-edge detection for bank n, and bit n+4 enables falling-edge detection for bank n. An edge whose enable bit is 0 sets no flag.
- R5: Offsets 8 to 11 read the per-line change flags of banks 0 to 3. Writing a byte there clears exactly the flags whose written bits are 1; flags are otherwise sticky.
- R6: A wide read at offset 8 returns the four flag bytes as one little-endian word: bank 0 in bits 7:0 and bank 3 in bits 31:24. A wide write at offset 8 clears every flag whose word bit is 1.
- R7: Reading offset 15 returns the interrupt output level in bit 0. Any write to offset 15 is a soft reset.
- R8: Every input line passes through two synchronizer flops. A flag is raised from the synchronized value within four clock cycles of a pin change.
- R9: The interrupt output is high exactly while any change flag is set. It stays high until every set flag has been cleared.
- R10: When an enabled edge and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: After hardware reset or soft reset, the following are all zero: outputs, the auxiliary output enable, control, enables and flags. Reads of offset 0 and offset 14 return 0.
- R12: Offset 7 returns the auxiliary port level. This level is the synchronized pins in input mode and the auxiliary output latch in output mode. Bank 3 edge detection follows the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Byte offset of the access |
| busWdata | input | 32 | Write data; bits 7:0 used for byte writes |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe; read data valid in the same cycle |
| busWide | input | 1 | 32-bit access qualifier, meaningful at offset 8 |
| busRdata | output | 32 | Read data, zero when no read |
| inPins | input | 24 | Input line levels |
| ttlIn | input | 8 | Auxiliary port pin levels |
| outPins | output | 24 | Output line drive values |
| ttlOut | output | 8 | Auxiliary port drive values |
| ttlOe | output | 1 | Auxiliary port output enable |
| irqOut | output | 1 | Interrupt, high while any flag is set |

## Verification
The delicate overlap is a software clear of a change flag landing in the same cycle that the synchronizer delivers a new enabled edge on that line. The bench first establishes the flag, then lets the line fall with falling detection disabled. It then raises the line again and asserts the clearing write two clock edges later, which is exactly the edge where the synchronized rise reaches the flag. A following read must still show the flag set. A plain clear with no edge then shows that the same write does clear it.

// File: rtl/cosio_pkg.sv
package cosio_pkg;
  parameter int BANK_W = 8;
  parameter int IN_BANKS = 3;
  parameter int SYNC_STAGES = 2;
  localparam int NUM_BANKS = IN_BANKS + 1;
  localparam int IN_W = IN_BANKS * BANK_W;
  localparam int ST_W = NUM_BANKS * BANK_W;
  localparam int ADDR_W = 4;
  localparam int TTL_DIR_BIT = 1;

  localparam logic [ADDR_W-1:0] OFF_TTL_OUT = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_TTL_IN = 4'd7;
  localparam logic [ADDR_W-1:0] OFF_ST0 = 4'd8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'd12;
  localparam logic [ADDR_W-1:0] OFF_EN = 4'd14;
  localparam logic [ADDR_W-1:0] OFF_RST = 4'd15;

  typedef struct packed {
    logic [NUM_BANKS-1:0] wrOut;
    logic wrCtrl;
    logic wrEnable;
    logic softRst;
    logic [ST_W-1:0] clrMask;
    logic [BANK_W-1:0] data;
  } cosStrobe_t;

  typedef struct packed {
    logic [IN_W-1:0] outLatch;
    logic [BANK_W-1:0] ttlLatch;
    logic [IN_W-1:0] inLvl;
    logic [BANK_W-1:0] ttlLvl;
    logic [ST_W-1:0] status;
    logic [BANK_W-1:0] ctrl;
    logic [BANK_W-1:0] enable;
    logic irq;
  } cosView_t;
endpackage

// File: rtl/cosio_ctrl.sv
module cosio_ctrl
  import cosio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ST_W-1:0] busWdata,
  input  logic busWr,
  input  logic busRd,
  input  logic busWide,
  input  cosView_t view,
  output cosStrobe_t stb,
  output logic [ST_W-1:0] busRdata
);
  logic [1:0] lane;
  assign lane = busAddr[1:0];

  always_comb begin
    stb = '0;
    stb.data = busWdata[BANK_W-1:0];
    if (busWr) begin
      case (busAddr)
        4'd0, 4'd1, 4'd2, OFF_TTL_OUT: stb.wrOut[lane] = 1'b1;
        4'd8, 4'd9, 4'd10, 4'd11: begin
          if (busWide && busAddr == OFF_ST0) stb.clrMask = busWdata;
          else stb.clrMask = ST_W'(busWdata[BANK_W-1:0]) << (BANK_W * int'(lane));
        end
        OFF_CTRL: stb.wrCtrl = 1'b1;
        OFF_EN: stb.wrEnable = 1'b1;
        OFF_RST: stb.softRst = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        4'd0, 4'd1, 4'd2: busRdata = ST_W'(view.outLatch[int'(lane)*BANK_W +: BANK_W]);
        OFF_TTL_OUT: busRdata = ST_W'(view.ttlLatch);
        4'd4, 4'd5, 4'd6: busRdata = ST_W'(view.inLvl[int'(lane)*BANK_W +: BANK_W]);
        OFF_TTL_IN: busRdata = ST_W'(view.ttlLvl);
        4'd8, 4'd9, 4'd10, 4'd11: begin
          if (busWide && busAddr == OFF_ST0) busRdata = view.status;
          else busRdata = ST_W'(view.status[int'(lane)*BANK_W +: BANK_W]);
        end
        OFF_CTRL: busRdata = ST_W'(view.ctrl);
        OFF_EN: busRdata = ST_W'(view.enable);
        OFF_RST: busRdata = ST_W'(view.irq);
        default: busRdata = '0;
      endcase
    end
  end

  // R2: writes to the read-only input offsets raise no strobe
  assert_input_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr inside {[4'd4:4'd7]}) |->
      (stb.wrOut == '0 && !stb.wrCtrl && !stb.wrEnable && !stb.softRst && stb.clrMask == '0));
endmodule

// File: rtl/cosio_dp.sv
module cosio_dp
  import cosio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cosStrobe_t stb,
  input  logic [IN_W-1:0] inPins,
  input  logic [BANK_W-1:0] ttlIn,
  output cosView_t view,
  output logic [IN_W-1:0] outPins,
  output logic [BANK_W-1:0] ttlOut,
  output logic ttlOe,
  output logic irqOut
);
  logic [IN_W-1:0] outLatch;
  logic [BANK_W-1:0] ttlLatch, ctrlReg, enReg;
  logic [ST_W-1:0] status, prevLvl, lvl, hit;
  logic [ST_W-1:0] syncQ [SYNC_STAGES];
  logic [ST_W-1:0] syncOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevLvl <= '0;
    end else begin
      syncQ[0] <= {ttlIn, inPins};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevLvl <= lvl;
    end
  end

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign lvl = {ctrlReg[TTL_DIR_BIT] ? ttlLatch : syncOut[ST_W-1:IN_W], syncOut[IN_W-1:0]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] cur, old;
    assign cur = lvl[b*BANK_W +: BANK_W];
    assign old = prevLvl[b*BANK_W +: BANK_W];
    assign hit[b*BANK_W +: BANK_W] = ((cur & ~old) & {BANK_W{enReg[b]}})
                                   | ((~cur & old) & {BANK_W{enReg[b+NUM_BANKS]}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outLatch <= '0;
      ttlLatch <= '0;
      ctrlReg <= '0;
      enReg <= '0;
      status <= '0;
    end else if (stb.softRst) begin
      outLatch <= '0;
      ttlLatch <= '0;
      ctrlReg <= '0;
      enReg <= '0;
      status <= '0;
    end else begin
      for (int b = 0; b < IN_BANKS; b++)
        if (stb.wrOut[b]) outLatch[b*BANK_W +: BANK_W] <= stb.data;
      if (stb.wrOut[NUM_BANKS-1]) ttlLatch <= stb.data;
      if (stb.wrCtrl) ctrlReg <= stb.data;
      if (stb.wrEnable) enReg <= stb.data;
      status <= (status & ~stb.clrMask) | hit;
    end
  end

  assign outPins = outLatch;
  assign ttlOut = ttlLatch;
  assign ttlOe = ctrlReg[TTL_DIR_BIT];
  assign irqOut = |status;

  assign view = '{outLatch: outLatch, ttlLatch: ttlLatch, inLvl: syncOut[IN_W-1:0],
                  ttlLvl: lvl[ST_W-1:IN_W], status: status, ctrl: ctrlReg,
                  enable: enReg, irq: irqOut};

  // R5: a flag only drops when its clear bit was written
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.softRst) |-> ((($past(status) & ~$past(stb.clrMask)) & ~status) == '0));

  // R4: with every enable off, no new flag can appear
  assert_disabled_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enReg) == '0) |-> ((status & ~$past(status)) == '0));

  // R10: a detected edge survives a same-cycle clear
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0 && !stb.softRst) |=> ((status & $past(hit)) == $past(hit)));

  // R9: interrupt held while an uncleared flag remains
  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && ((status & ~stb.clrMask) != '0) && !stb.softRst) |=> irqOut);

  // R7: soft reset zeroes the software-visible state
  assert_softrst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.softRst |=> (status == '0 && outPins == '0 && !ttlOe && enReg == '0));
endmodule

// File: rtl/cosio_regs.sv
module cosio_regs
  import cosio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic [3:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic busWr,
  input  logic busRd,
  input  logic busWide,
  output logic [31:0] busRdata,
  input  logic [23:0] inPins,
  input  logic [7:0] ttlIn,
  output logic [23:0] outPins,
  output logic [7:0] ttlOut,
  output logic ttlOe,
  output logic irqOut
);
  cosStrobe_t stb;
  cosView_t view;

  cosio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busWide(busWide), .view(view),
    .stb(stb), .busRdata(busRdata)
  );

  cosio_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inPins(inPins), .ttlIn(ttlIn),
    .view(view), .outPins(outPins), .ttlOut(ttlOut), .ttlOe(ttlOe), .irqOut(irqOut)
  );
endmodule

// File: tb/cosio_regs_test.sv
module cosio_regs_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busWr = 0, busRd = 0, busWide = 0;
  logic [31:0] busRdata;
  logic [23:0] inPins = '0;
  logic [7:0] ttlIn = '0;
  logic [23:0] outPins;
  logic [7:0] ttlOut;
  logic ttlOe, irqOut;

  int total = 0, bad = 0, cycles = 0;
  logic probe = 0;

  typedef struct {int kind; logic [31:0] exp; string tag;} item_t;
  item_t q[$];

  cosio_regs uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .busRd(busRd), .busWide(busWide), .busRdata(busRdata), .inPins(inPins), .ttlIn(ttlIn),
    .outPins(outPins), .ttlOut(ttlOut), .ttlOe(ttlOe), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  // monitor: pops one expected item per probe and compares mid-cycle
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = busRdata;
        1: act = 32'(outPins);
        2: act = 32'(ttlOut);
        3: act = 32'(ttlOe);
        default: act = 32'(irqOut);
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic w = 0);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWide = w; busWr = 1;
    @(posedge clk); #1;
    busWr = 0; busWide = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag, input logic w = 0);
    @(posedge clk); #1;
    busAddr = a; busWide = w; busRd = 1;
    q.push_back('{0, e, tag}); probe = 1;
    @(posedge clk); #1;
    busRd = 0; busWide = 0; probe = 0;
  endtask

  task automatic pin(input int k, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    q.push_back('{k, e, tag}); probe = 1;
    @(posedge clk); #1;
    probe = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    idle(3); #1 rst_n = 1;
    // R11 reset state
    rd(4'd0, 0, "R11 out0 after reset");
    rd(4'd14, 0, "R11 enable after reset");
    pin(3, 0, "R11 ttlOe after reset");
    pin(4, 0, "R11 irq after reset");
    // R1 output latches
    wr(4'd0, 32'hA5); wr(4'd1, 32'h3C); wr(4'd2, 32'h81);
    pin(1, 32'h813CA5, "R1 output pins");
    rd(4'd1, 32'h3C, "R1 readback");
    // R2 input writes ignored, levels read
    wr(4'd4, 32'hFF); wr(4'd7, 32'hFF);
    pin(1, 32'h813CA5, "R2 outputs unchanged by input write");
    rd(4'd8, 0, "R2 no flags from input write", 1);
    inPins = 24'h123456; idle(4);
    rd(4'd4, 32'h56, "R2 R8 input bank0 level");
    rd(4'd6, 32'h12, "R2 input bank2 level");
    // R4 rising only on bank 0
    wr(4'd14, 32'h01);
    inPins = 24'h123457; idle(4);
    inPins = 24'h123456; idle(4);
    rd(4'd8, 32'h01, "R4 R8 bank0 rise flagged, fall ignored");
    pin(4, 1, "R9 irq with flag");
    rd(4'd15, 1, "R7 irq readback");
    // R4 falling only on bank 1 (bit 5)
    wr(4'd14, 32'h20);
    inPins = 24'h123056; idle(4);
    inPins = 24'h123856; idle(4);
    rd(4'd9, 32'h04, "R4 bank1 fall flagged, rise ignored");
    rd(4'd8, 32'h00000401, "R6 wide read", 1);
    // R5 R6 R9 clears
    wr(4'd8, 32'h01);
    rd(4'd8, 0, "R5 byte clear");
    pin(4, 1, "R9 irq held while bank1 flag set");
    wr(4'd8, 32'h00000400, 1);
    rd(4'd8, 0, "R6 wide clear", 1);
    pin(4, 0, "R9 irq drops after all cleared");
    // R10 set wins over same-cycle clear
    wr(4'd14, 32'h04);
    inPins = 24'h133856; idle(4);
    rd(4'd10, 32'h01, "R4 bank2 rise");
    inPins = 24'h123856; idle(4);
    @(posedge clk); #1 inPins = 24'h133856;
    @(posedge clk);
    @(posedge clk); #1 busAddr = 4'd10; busWdata = 32'h01; busWr = 1;
    @(posedge clk); #1 busWr = 0;
    rd(4'd10, 32'h01, "R10 edge beats clear");
    wr(4'd10, 32'h01);
    rd(4'd10, 0, "R5 clear without edge");
    // R12 R3 auxiliary port
    ttlIn = 8'h5A; idle(4);
    wr(4'd14, 32'h08);
    rd(4'd7, 32'h5A, "R12 input-mode level");
    ttlIn = 8'h5B; idle(4);
    rd(4'd11, 32'h01, "R12 bank3 pin rise");
    wr(4'd11, 32'h01);
    wr(4'd12, 32'h02);
    pin(3, 1, "R3 output enable set");
    wr(4'd3, 32'hF0); idle(2);
    rd(4'd7, 32'hF0, "R12 output-mode level");
    rd(4'd11, 32'hF0, "R12 bank3 latch rise");
    pin(2, 32'hF0, "R1 aux output pins");
    rd(4'd3, 32'hF0, "R1 aux latch readback");
    wr(4'd11, 32'h30);
    rd(4'd11, 32'hC0, "R5 partial clear");
    rd(4'd12, 32'h02, "R3 control readback");
    // R7 R11 soft reset
    wr(4'd15, 32'h0);
    pin(1, 0, "R11 outputs after soft reset");
    pin(3, 0, "R3 R11 input mode after soft reset");
    rd(4'd8, 0, "R7 flags after soft reset", 1);
    rd(4'd14, 0, "R11 enable after soft reset");
    pin(4, 0, "R7 irq after soft reset");
    idle(2);
    finishRun();
  end
endmodule